// File: doc/BRIEF.md
# I2C Register-File Slave with Calibration ROM Window

This block is a byte-oriented slave for a two-wire I2C-style bus. It gives a host controller read and write access to a bank of 8-bit configuration registers. SCL and SDA are sampled with a fast system clock. Each line passes through a two-flop synchronizer, and the block finds bus edges, START and STOP in the synchronized domain. SDA is open-drain: the block only asserts an enable that pulls the line low.

The 7-bit device address is `11000` followed by two bits set by a three-state strap. A write transaction carries a register pointer and then data bytes, and the pointer increments after each byte. A read transaction returns bytes from the pointer onward for as long as the master acknowledges. Three addresses are read-only. Two of them show external status inputs. The third is a window into a 16-entry calibration ROM, and the entry it shows is chosen by the low bits of another register. A write to register 0x04 fires a one-cycle trigger for the VCO autoselect logic.

Top module: `i2c_cfg_slave`

## Requirements
- R1: After reset all registers hold 0x00, `sda_oe` is low and `vas_trig` is low.
- R2: The device address is 0x60 when the strap reads low (`strap_hi`=0, `strap_open`=0), 0x61 when it reads high (`strap_hi`=1) and 0x62 when it is floating (`strap_open`=1, which wins). Any other address gets no ACK, and every later byte is ignored until the next START.
- R3: The slave ACKs on the ninth clock by driving SDA low. It does this for a matching address byte, for the pointer byte and for every write data byte, including data bytes that are discarded.
- R4: In a write (R/W=0), the first byte after the address is loaded into the register pointer. Each following byte, received MSB first, goes to the pointed register, and the pointer then increments. Register contents change only on a synchronized SCL falling edge.
- R5: A START with R/W=1 (normally a repeated START) returns the byte at the pointer, MSB first. The slave moves on to the next register for as long as the master ACKs.
- R6: When the master NACKs a read byte, the slave releases SDA. It then drives nothing until the next START.
- R7: Writes to 0x10, 0x11 and 0x12 are ACKed but change nothing. 0x11 reads input `stat_a`, 0x12 reads input `stat_b`, and these three slots of `cfg_o` stay 0x00.
- R8: A data byte written to 0x04 produces exactly one single-cycle pulse on `vas_trig`. Writes to other addresses produce none.
- R9: A read of 0x10 returns the ROM entry k selected by bits [3:0] of register 0x0E. For k < 13 the entry is (37*k + 17) mod 256. For k of 13 to 15 it is 0x00.
- R10: Data written to pointers above 0x15 is discarded, and reads of those pointers return 0x00.
- R11: A START in the middle of a byte restarts the address phase. A STOP in the middle of a byte ends the transaction, and the partial byte is not written.
- R12: `sda_oe` changes only after a synchronized SCL falling edge, START or STOP. It never changes while SCL is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling system clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | When high, the pad pulls SDA low |
| strap_hi | input | 1 | Address strap reads high |
| strap_open | input | 1 | Address strap is floating |
| stat_a | input | 8 | Status shown at register 0x11 |
| stat_b | input | 8 | Status shown at register 0x12 |
| cfg_o | output | 176 | All register slots, slot i at bits [8i+7:8i] |
| vas_trig | output | 1 | One-cycle pulse when register 0x04 is written |

## Verification
On every cycle the assertions check four things: `vas_trig` lasts exactly one cycle and follows an SCL falling edge; SDA is never driven while the slave is idle; the drive enable and the register contents move only on a falling edge, START or STOP; and the bit counter stays inside the nine-slot frame. Only the bench scenarios can show the rest. These are the values behind addressing under each strap setting, auto-increment in both directions, protection of the read-only slots, the ROM formula, discarding beyond the last register, and recovery after an aborted byte.

// File: rtl/i2c_cfg_slave.sv
module i2c_cfg_slave #(
  parameter int           NREG       = 22,
  parameter int           ROM_DEPTH  = 16,
  parameter int           ROM_USED   = 13,
  parameter logic [4:0]   ADDR_HI    = 5'b11000,
  parameter logic [7:0]   TRIG_REG   = 8'h04,
  parameter logic [7:0]   ROMSEL_REG = 8'h0E,
  parameter logic [7:0]   ROMRD_REG  = 8'h10,
  parameter logic [7:0]   STA_REG    = 8'h11,
  parameter logic [7:0]   STB_REG    = 8'h12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic              strap_hi,
  input  logic              strap_open,
  input  logic [7:0]        stat_a,
  input  logic [7:0]        stat_b,
  output logic [NREG*8-1:0] cfg_o,
  output logic              vas_trig
);
  localparam int         PW       = $clog2(NREG);
  localparam int         AW       = $clog2(ROM_DEPTH);
  localparam logic [7:0] LAST_REG = 8'(NREG - 1);
  localparam int         SEL_I    = int'(ROMSEL_REG);

  typedef enum logic [2:0] {S_IDLE, S_DEV, S_PTR, S_WR, S_RD} st_t;

  st_t        state;
  logic [2:0] scl_p, sda_p;
  logic [3:0] cnt;
  logic [7:0] shreg, ptr, rd_byte, rom_byte;
  logic [6:0] txb;
  logic       rw, mack;
  logic [7:0] regs [NREG];

  wire scl_s = scl_p[1];
  wire scl_d = scl_p[2];
  wire sda_s = sda_p[1];
  wire sda_d = sda_p[2];

  wire scl_rise = scl_s & ~scl_d;
  wire scl_fall = ~scl_s & scl_d;
  wire start_c  = scl_s & scl_d & sda_d & ~sda_s;
  wire stop_c   = scl_s & scl_d & ~sda_d & sda_s;
  wire idle_w   = (state == S_IDLE);

  wire [6:0] dev_addr = {ADDR_HI, strap_open ? 2'b10 : {1'b0, strap_hi}};
  wire [AW-1:0] rom_idx = regs[SEL_I][AW-1:0];
  wire wr_ok = (ptr <= LAST_REG) && (ptr != ROMRD_REG) &&
               (ptr != STA_REG) && (ptr != STB_REG);

  always_comb begin
    if (int'(rom_idx) < ROM_USED)
      rom_byte = 8'(rom_idx) * 8'd37 + 8'd17;
    else
      rom_byte = 8'h00;
  end

  always_comb begin
    if (ptr == ROMRD_REG)      rd_byte = rom_byte;
    else if (ptr == STA_REG)   rd_byte = stat_a;
    else if (ptr == STB_REG)   rd_byte = stat_b;
    else if (ptr <= LAST_REG)  rd_byte = regs[ptr[PW-1:0]];
    else                       rd_byte = 8'h00;
  end

  for (genvar i = 0; i < NREG; i++) begin : g_out
    assign cfg_o[8*i +: 8] = regs[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_p <= 3'b111;
      sda_p <= 3'b111;
    end else begin
      scl_p <= {scl_p[1:0], scl_i};
      sda_p <= {sda_p[1:0], sda_i};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      cnt      <= 4'd0;
      shreg    <= 8'h00;
      txb      <= 7'h00;
      ptr      <= 8'h00;
      rw       <= 1'b0;
      mack     <= 1'b0;
      sda_oe   <= 1'b0;
      vas_trig <= 1'b0;
      for (int i = 0; i < NREG; i++) regs[i] <= 8'h00;
    end else begin
      vas_trig <= 1'b0;
      if (start_c) begin
        state  <= S_DEV;
        cnt    <= 4'd0;
        sda_oe <= 1'b0;
      end else if (stop_c) begin
        state  <= S_IDLE;
        cnt    <= 4'd0;
        sda_oe <= 1'b0;
      end else if (!idle_w) begin
        if (scl_rise) begin
          if (cnt < 4'd8) begin
            shreg <= {shreg[6:0], sda_s};
            cnt   <= cnt + 4'd1;
          end else if (cnt == 4'd8) begin
            mack <= ~sda_s;
            cnt  <= 4'd9;
          end
        end
        if (scl_fall) begin
          if (cnt == 4'd8) begin
            unique case (state)
              S_DEV: begin
                if (shreg[7:1] == dev_addr) begin
                  sda_oe <= 1'b1;
                  rw     <= shreg[0];
                end else begin
                  state <= S_IDLE;
                end
              end
              S_PTR: begin
                ptr    <= shreg;
                sda_oe <= 1'b1;
              end
              S_WR: begin
                if (wr_ok) regs[ptr[PW-1:0]] <= shreg;
                if (ptr == TRIG_REG) vas_trig <= 1'b1;
                ptr    <= ptr + 8'd1;
                sda_oe <= 1'b1;
              end
              default: sda_oe <= 1'b0;
            endcase
          end else if (cnt == 4'd9) begin
            cnt    <= 4'd0;
            sda_oe <= 1'b0;
            unique case (state)
              S_DEV: begin
                if (rw) begin
                  state  <= S_RD;
                  txb    <= rd_byte[6:0];
                  sda_oe <= ~rd_byte[7];
                  ptr    <= ptr + 8'd1;
                end else begin
                  state <= S_PTR;
                end
              end
              S_PTR: state <= S_WR;
              S_RD: begin
                if (mack) begin
                  txb    <= rd_byte[6:0];
                  sda_oe <= ~rd_byte[7];
                  ptr    <= ptr + 8'd1;
                end else begin
                  state <= S_IDLE;
                end
              end
              default: ;
            endcase
          end else if (cnt != 4'd0 && state == S_RD) begin
            sda_oe <= ~txb[6];
            txb    <= {txb[5:0], 1'b0};
          end
        end
      end
    end
  end
endmodule

module i2c_cfg_slave_chk #(
  parameter int NREG = 22
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sda_oe,
  input logic              vas_trig,
  input logic              scl_fall,
  input logic              start_c,
  input logic              stop_c,
  input logic              idle,
  input logic [3:0]        cnt,
  input logic [NREG*8-1:0] cfg_o
);
  // R8
  trig_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vas_trig |=> !vas_trig);
  // R8
  trig_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vas_trig |-> $past(scl_fall));
  // R6
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> !sda_oe);
  // R12
  oe_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> ($past(scl_fall) || $past(start_c) || $past(stop_c)));
  // R4
  cfg_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cfg_o) |-> $past(scl_fall));
  // R11
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= 4'd9);
endmodule

bind i2c_cfg_slave i2c_cfg_slave_chk #(.NREG(NREG)) u_chk (
  .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe), .vas_trig(vas_trig),
  .scl_fall(scl_fall), .start_c(start_c), .stop_c(stop_c),
  .idle(idle_w), .cnt(cnt), .cfg_o(cfg_o)
);

// File: tb/i2c_cfg_slave_bench.sv
module i2c_cfg_slave_bench;
  localparam int NREG = 22;
  localparam int Q    = 10;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic strap_hi = 1'b0, strap_open = 1'b0;
  logic [7:0] stat_a = 8'h5A, stat_b = 8'hC3;
  logic sda_oe, vas_trig;
  logic [NREG*8-1:0] cfg;
  wire sda_bus = sda_m & ~sda_oe;

  i2c_cfg_slave u_i2c_cfg_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe(sda_oe),
    .strap_hi(strap_hi), .strap_open(strap_open), .stat_a(stat_a), .stat_b(stat_b),
    .cfg_o(cfg), .vas_trig(vas_trig)
  );

  int checks = 0, fails = 0, trig_cnt = 0, oe_viol = 0;
  logic done = 1'b0;
  logic prev_oe = 1'b0, prev_scl = 1'b1;

  always @(posedge clk) if (rst_n && vas_trig) trig_cnt++;

  always @(negedge clk) begin
    if (rst_n && prev_scl && scl_m && (prev_oe !== sda_oe)) oe_viol++;
    prev_oe  = sda_oe;
    prev_scl = scl_m;
  end

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  logic [7:0] exp_v [$];
  string      exp_t [$];
  logic [7:0] got_v;
  event       rd_ev;

  initial forever begin
    @(rd_ev);
    checks++;
    if (exp_v.size() == 0) begin
      fails++;
      $display("FAIL unexpected read got=%0h exp=none", got_v);
    end else begin
      logic [7:0] e;
      string t;
      e = exp_v.pop_front();
      t = exp_t.pop_front();
      if (got_v !== e) begin
        fails++;
        $display("FAIL %s read got=%0h exp=%0h", t, got_v, e);
      end
    end
  end

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic i2c_start();
    sda_m = 1'b1; wq(Q);
    scl_m = 1'b1; wq(Q);
    sda_m = 1'b0; wq(Q);
    scl_m = 1'b0; wq(Q);
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; wq(Q);
    scl_m = 1'b1; wq(Q);
    sda_m = 1'b1; wq(Q);
  endtask

  task automatic put_bit(input logic b);
    sda_m = b;    wq(Q);
    scl_m = 1'b1; wq(2*Q);
    scl_m = 1'b0; wq(Q);
  endtask

  task automatic get_bit(output logic b);
    sda_m = 1'b1; wq(Q);
    scl_m = 1'b1; wq(Q);
    b = sda_bus;  wq(Q);
    scl_m = 1'b0; wq(Q);
  endtask

  task automatic send_byte(input logic [7:0] v, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    get_bit(b);
    ack = ~b;
  endtask

  task automatic recv_byte(input logic ack_it, output logic [7:0] v);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      get_bit(b);
      v[i] = b;
    end
    put_bit(~ack_it);
  endtask

  task automatic wr(input logic [6:0] dev, input logic [7:0] p,
                    input logic [7:0] d [4], input int n, input string tag);
    logic a;
    i2c_start();
    send_byte({dev, 1'b0}, a); check({tag, " R3 addr ack"}, 32'(a), 1);
    send_byte(p, a);           check({tag, " R3 ptr ack"}, 32'(a), 1);
    for (int i = 0; i < n; i++) begin
      send_byte(d[i], a);
      check({tag, " R3 data ack"}, 32'(a), 1);
    end
    i2c_stop();
  endtask

  task automatic rd(input logic [6:0] dev, input logic [7:0] p,
                    input logic [7:0] e [4], input int n, input string tag);
    logic a;
    logic [7:0] v;
    i2c_start();
    send_byte({dev, 1'b0}, a); check({tag, " R3 addr ack"}, 32'(a), 1);
    send_byte(p, a);           check({tag, " R3 ptr ack"}, 32'(a), 1);
    i2c_start();
    send_byte({dev, 1'b1}, a); check({tag, " R5 raddr ack"}, 32'(a), 1);
    for (int i = 0; i < n; i++) begin
      exp_v.push_back(e[i]);
      exp_t.push_back(tag);
      recv_byte(i < n - 1, v);
      got_v = v;
      -> rd_ev;
    end
    i2c_stop();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic a;
    logic [7:0] v;
    wq(5);
    check("R1 reset sda_oe", 32'(sda_oe), 0);
    check("R1 reset vas_trig", 32'(vas_trig), 0);
    check("R1 reset regs", 32'(|cfg), 0);
    rst_n = 1'b1;
    wq(5);

    // R4 multi-byte write with auto-increment, R5 read back
    wr(7'h60, 8'h00, '{8'hA5, 8'h3C, 8'h71, 8'h00}, 3, "R4 wr0");
    check("R4 reg0", 32'(cfg[7:0]), 32'hA5);
    check("R4 reg1", 32'(cfg[15:8]), 32'h3C);
    check("R4 reg2", 32'(cfg[23:16]), 32'h71);
    check("R8 no trig on 0..2", trig_cnt, 0);
    rd(7'h60, 8'h00, '{8'hA5, 8'h3C, 8'h71, 8'h00}, 3, "R5 rd0");

    // R8 trigger on 0x04 only
    wr(7'h60, 8'h03, '{8'h11, 8'h22, 8'h00, 8'h00}, 2, "R8 wr3");
    check("R8 one trig", trig_cnt, 1);
    wr(7'h60, 8'h05, '{8'h33, 8'h00, 8'h00, 8'h00}, 1, "R8 wr5");
    check("R8 no trig on 5", trig_cnt, 1);

    // R9 ROM window
    wr(7'h60, 8'h0E, '{8'h05, 8'h00, 8'h00, 8'h00}, 1, "R9 sel5");
    rd(7'h60, 8'h10, '{8'hCA, 8'h00, 8'h00, 8'h00}, 1, "R9 rom5");
    wr(7'h60, 8'h0E, '{8'h0E, 8'h00, 8'h00, 8'h00}, 1, "R9 sel14");
    rd(7'h60, 8'h10, '{8'h00, 8'h00, 8'h00, 8'h00}, 1, "R9 rom14");
    wr(7'h60, 8'h0E, '{8'h1C, 8'h00, 8'h00, 8'h00}, 1, "R9 sel12");
    rd(7'h60, 8'h0E, '{8'h1C, 8'h00, 8'hCD, 8'h5A}, 4, "R9 window");

    // R7 read-only slots
    wr(7'h60, 8'h10, '{8'hFF, 8'hFF, 8'hFF, 8'h77}, 4, "R7 wr ro");
    rd(7'h60, 8'h10, '{8'hCD, 8'h5A, 8'hC3, 8'h77}, 4, "R7 rd ro");
    check("R7 ro slots", 32'(cfg[8*16 +: 24]), 0);

    // R10 beyond last register
    wr(7'h60, 8'h15, '{8'h9E, 8'h44, 8'h00, 8'h00}, 2, "R10 wr15");
    rd(7'h60, 8'h15, '{8'h9E, 8'h00, 8'h00, 8'h00}, 2, "R10 rd15");
    wr(7'h60, 8'h80, '{8'h55, 8'h00, 8'h00, 8'h00}, 1, "R10 wr80");
    rd(7'h60, 8'h80, '{8'h00, 8'h00, 8'h00, 8'h00}, 1, "R10 rd80");

    // R2 mismatching address is ignored
    i2c_start();
    send_byte({7'h61, 1'b0}, a); check("R2 no ack 0x61", 32'(a), 0);
    send_byte(8'h00, a);         check("R2 ignored ptr", 32'(a), 0);
    send_byte(8'h11, a);         check("R2 ignored data", 32'(a), 0);
    i2c_stop();
    check("R2 reg0 kept", 32'(cfg[7:0]), 32'hA5);

    strap_hi = 1'b1;
    wq(4);
    i2c_start();
    send_byte({7'h60, 1'b0}, a); check("R2 strap high 0x60 nack", 32'(a), 0);
    i2c_stop();
    rd(7'h61, 8'h01, '{8'h3C, 8'h00, 8'h00, 8'h00}, 1, "R2 strap high");
    strap_open = 1'b1;
    wq(4);
    rd(7'h62, 8'h02, '{8'h71, 8'h00, 8'h00, 8'h00}, 1, "R2 strap open");
    strap_hi = 1'b0;
    strap_open = 1'b0;
    wq(4);

    // R6 after NACK the slave stays off the bus
    i2c_start();
    send_byte({7'h60, 1'b0}, a);
    send_byte(8'h00, a);
    i2c_start();
    send_byte({7'h60, 1'b1}, a);
    recv_byte(1'b0, v);
    check("R6 nack byte", 32'(v), 32'hA5);
    check("R6 released", 32'(sda_oe), 0);
    recv_byte(1'b0, v);
    check("R6 quiet after nack", 32'(v), 32'hFF);
    i2c_stop();

    // R11 START mid-byte restarts address phase
    i2c_start();
    put_bit(1'b1); put_bit(1'b0); put_bit(1'b1); put_bit(1'b1);
    rd(7'h60, 8'h00, '{8'hA5, 8'h00, 8'h00, 8'h00}, 1, "R11 restart");
    // R11 STOP mid-byte drops the partial byte
    i2c_start();
    send_byte({7'h60, 1'b0}, a);
    send_byte(8'h00, a);
    put_bit(1'b0); put_bit(1'b0); put_bit(1'b0);
    i2c_stop();
    check("R11 partial not written", 32'(cfg[7:0]), 32'hA5);

    wq(20);
    check("R12 no sda change while scl high", oe_viol, 0);
    check("R5 scoreboard drained", exp_v.size(), 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule